// File: doc/BRIEF.md
# RAM-Based Segmented Content-Addressable Memory

This block looks up a wide search key in a small table of stored keys, such as addresses used to classify packets. It reports every table entry that holds that exact key. Instead of keeping one compare register per entry, it stores the table transposed in ordinary synchronous RAMs.

The key is cut into byte segments, and each segment has its own RAM. A segment byte is used directly as the RAM address. Each RAM word holds one bit per table entry, and that bit is set when the entry's key has that byte value in that segment. A search reads one word from every segment RAM in the same cycle. It then ANDs the words, so an entry survives only if all of its segments agree. The result is a hit vector, a hit flag and the lowest matching entry number.

Entries are written or deleted through an update port. An update rewrites the entry's bit column over every address of every segment RAM, so the table stays consistent without knowing the entry's old key. After reset the block clears the whole array by itself. It raises a busy flag while any sweep is running.

Top module: `segcam_top`

## Requirements
- R1: While reset is held and for exactly 256 clock cycles after it is released, `busy` is high; after that sweep a search reports no hit and an all-zero `res_vec`.
- R2: A search is accepted on the rising edge where `srch_valid` is high and `busy` is low. `res_valid` is high for exactly one cycle, after the second rising edge following acceptance (the acceptance edge and one more), and is low after the acceptance edge alone.
- R3: After entry j is written with key K, searching K sets `res_hit` and bit j of `res_vec` (bit position j corresponds to entry number j).
- R4: Segment s is key bits [8s+7:8s]; a search key differing from an entry's key in any single segment, including segment 0 or segment 15, does not match that entry.
- R5: When several entries match, `res_vec` shows all of them and `res_index` is the lowest-numbered one; with no match `res_index` is 0.
- R6: An update accepted on a rising edge (`upd_valid` high, `busy` low) makes `busy` high for exactly 256 cycles starting after that edge.
- R7: A search presented while `busy` is high is ignored: `res_valid` stays low for it.
- R8: Deleting entry j (`upd_op` = 0) makes it never match again, while other entries holding the same key still match.
- R9: Writing a new key to an entry that already holds a key (`upd_op` = 1) removes the old key: the old key no longer matches that entry.
- R10: An update request presented while `busy` is high is ignored and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_valid | input | 1 | Search request strobe |
| srch_key | input | 128 | Key to look up; segment s is bits [8s+7:8s] |
| upd_valid | input | 1 | Update request strobe |
| upd_op | input | 1 | 1 = write key to entry, 0 = delete entry |
| upd_entry | input | 4 | Entry number to update |
| upd_key | input | 128 | Key to store on a write |
| busy | output | 1 | A clearing or update sweep is in progress |
| res_valid | output | 1 | One-cycle pulse marking a search result |
| res_hit | output | 1 | At least one entry matched |
| res_index | output | 4 | Lowest-numbered matching entry, 0 if none |
| res_vec | output | 16 | One bit per entry that matched |

## Verification
The bench looks for keys that differ from a stored key only in the first or the last byte. An AND cascade that skips a segment would report a false hit on them. It stores the same key in entries 0 and 15, and in entries 2, 9 and 12. A priority encoder that picks the wrong end, or a hit vector truncated at the edges, would then report the wrong index or miss bits. It rewrites an entry with a new key and deletes an entry that shares its key with others. A sweep that leaves the old column bits set would keep a stale match; one that clears whole words would wipe the neighbouring entries. It also issues searches and update requests while a sweep is running. A design that accepts them would emit a result pulse or would quietly store a key that then matches.

// File: rtl/segcam_pkg.sv
package segcam_pkg;

  typedef enum logic [1:0] {
    SW_INIT = 2'd0,
    SW_IDLE = 2'd1,
    SW_RUN  = 2'd2
  } sweep_state_t;

  // Position of the lowest set bit, 0 when none is set.
  function automatic int unsigned lowest_set(input logic [63:0] v);
    int unsigned pos;
    pos = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) pos = i;
    end
    return pos;
  endfunction

  // Single bit at position i.
  function automatic logic [63:0] bit_at(input int unsigned i);
    return 64'(1) << i;
  endfunction

endpackage

// File: rtl/segcam_seg_ram.sv
module segcam_seg_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_mask,
  input  logic [DW-1:0] wr_bits
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Bit-masked write: only the masked entry columns change.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= (mem[wr_addr] & ~wr_mask) | (wr_bits & wr_mask);
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/segcam_sweeper.sv
module segcam_sweeper
  import segcam_pkg::*;
#(
  parameter int AW      = 8,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               req_write,
  input  logic [IDX_W-1:0]   req_entry,
  output logic               accept,
  output logic               busy,
  output logic               run_write,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [ENTRIES-1:0] wr_mask
);
  localparam logic [AW-1:0] LAST = '1;

  sweep_state_t       state;
  logic [AW-1:0]      addr;
  logic [IDX_W-1:0]   entry_q;
  logic               write_q;
  logic               at_last;

  assign at_last   = (addr == LAST);
  assign busy      = (state != SW_IDLE);
  assign accept    = (state == SW_IDLE) && req;
  assign run_write = (state == SW_RUN) && write_q;
  assign wr_en     = busy;
  assign wr_addr   = addr;
  assign wr_mask   = (state == SW_INIT) ? '1 : ENTRIES'(bit_at(32'(entry_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SW_INIT;
      addr    <= '0;
      entry_q <= '0;
      write_q <= 1'b0;
    end else begin
      case (state)
        SW_INIT, SW_RUN: begin
          addr <= addr + 1'b1;
          if (at_last) state <= SW_IDLE;
        end
        SW_IDLE: begin
          if (req) begin
            state   <= SW_RUN;
            entry_q <= req_entry;
            write_q <= req_write;
          end
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  // Addresses advance by one on every sweep cycle (R6, R1)
  assert_sweep_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && addr != '0) |-> (addr == $past(addr) + 1'b1));

  // An update sweep touches exactly one entry column (R3)
  assert_single_column_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SW_RUN) |-> ($countones(wr_mask) == 1));

  // The sweep ends right after its last address (R6)
  assert_sweep_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SW_RUN && at_last) |=> !busy);
endmodule

// File: rtl/segcam_match.sv
module segcam_match
  import segcam_pkg::*;
#(
  parameter int SEGS    = 16,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [SEGS-1:0][ENTRIES-1:0]  seg_vecs,
  output logic                          res_valid,
  output logic                          res_hit,
  output logic [IDX_W-1:0]              res_index,
  output logic [ENTRIES-1:0]            res_vec
);
  logic [ENTRIES-1:0] and_vec;
  logic [IDX_W-1:0]   low_idx;

  always_comb begin
    and_vec = '1;
    for (int s = 0; s < SEGS; s++) and_vec &= seg_vecs[s];
  end

  assign low_idx = IDX_W'(lowest_set(64'(and_vec)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_index <= '0;
      res_vec   <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_vec   <= and_vec;
        res_hit   <= |and_vec;
        res_index <= low_idx;
      end
    end
  end

  // A result pulse always follows a RAM read stage (R2)
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid));

  // Reported index is a set bit with nothing set below it (R5)
  assert_lowest_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |->
      (res_vec[res_index] && ((res_vec & ((ENTRIES'(1) << res_index) - 1'b1)) == '0)));

  // Hit flag agrees with the vector (R3)
  assert_hit_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (res_vec != '0)));
endmodule

// File: rtl/segcam_top.sv
module segcam_top #(
  parameter int KEY_W   = 128,
  parameter int SEG_W   = 8,
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       srch_valid,
  input  logic [KEY_W-1:0]           srch_key,
  input  logic                       upd_valid,
  input  logic                       upd_op,
  input  logic [$clog2(ENTRIES)-1:0] upd_entry,
  input  logic [KEY_W-1:0]           upd_key,
  output logic                       busy,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic [$clog2(ENTRIES)-1:0] res_index,
  output logic [ENTRIES-1:0]         res_vec
);
  localparam int SEGS  = KEY_W / SEG_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic                          srch_fire;
  logic                          rd_valid;
  logic                          upd_accept;
  logic                          run_write;
  logic                          wr_en;
  logic [SEG_W-1:0]              wr_addr;
  logic [ENTRIES-1:0]            wr_mask;
  logic [KEY_W-1:0]              key_q;
  logic [SEGS-1:0][ENTRIES-1:0]  seg_vecs;

  assign srch_fire = srch_valid && !busy;

  segcam_sweeper #(.AW(SEG_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (upd_valid),
    .req_write (upd_op),
    .req_entry (upd_entry),
    .accept    (upd_accept),
    .busy      (busy),
    .run_write (run_write),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_mask   (wr_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= srch_fire;
      if (upd_accept) key_q <= upd_key;
    end
  end

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    logic [ENTRIES-1:0] seg_bits;
    // Column bit is set only where the address equals this segment's key byte.
    assign seg_bits = (run_write && wr_addr == key_q[s*SEG_W +: SEG_W]) ? wr_mask : '0;

    segcam_seg_ram #(.AW(SEG_W), .DW(ENTRIES)) i_ram (
      .clk     (clk),
      .rd_en   (srch_fire),
      .rd_addr (srch_key[s*SEG_W +: SEG_W]),
      .rd_data (seg_vecs[s]),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_mask (wr_mask),
      .wr_bits (seg_bits)
    );
  end

  segcam_match #(.SEGS(SEGS), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rd_valid),
    .seg_vecs  (seg_vecs),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_index (res_index),
    .res_vec   (res_vec)
  );

  // Reads only start when no sweep is running (R7)
  assert_no_read_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!busy));

  // Update requests during a sweep leave the stored key untouched (R10)
  assert_upd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && busy) |=> $stable(key_q));
endmodule

// File: tb/test_segcam_top.sv
`timescale 1ns/1ps
module test_segcam_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         srch_valid = 1'b0;
  logic [127:0] srch_key = '0;
  logic         upd_valid = 1'b0;
  logic         upd_op = 1'b0;
  logic [3:0]   upd_entry = '0;
  logic [127:0] upd_key = '0;
  logic         busy, res_valid, res_hit;
  logic [3:0]   res_index;
  logic [15:0]  res_vec;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [127:0] mkey [16];
  bit           mval [16];

  always #2.5 clk = ~clk;

  segcam_top i_segcam_top (
    .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_key(srch_key),
    .upd_valid(upd_valid), .upd_op(upd_op), .upd_entry(upd_entry), .upd_key(upd_key),
    .busy(busy), .res_valid(res_valid), .res_hit(res_hit),
    .res_index(res_index), .res_vec(res_vec)
  );

  function automatic logic [127:0] mk(input int seed);
    logic [127:0] k;
    for (int b = 0; b < 16; b++) k[b*8 +: 8] = 8'(seed * 37 + b * 11 + 5);
    return k;
  endfunction

  function automatic logic [15:0] model_vec(input logic [127:0] k);
    logic [15:0] v;
    v = '0;
    for (int j = 0; j < 16; j++) if (mval[j] && mkey[j] == k) v[j] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    while (busy && cnt < 400) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic do_update(input bit op, input int entry, input logic [127:0] k, input string tag);
    int cnt;
    @(negedge clk);
    upd_valid = 1'b1; upd_op = op; upd_entry = 4'(entry); upd_key = k;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    wait_idle(cnt);
    chk(cnt == 256, tag, "busy cycles (R6)", 128'(cnt), 128'd256);
    mval[entry] = op;
    mkey[entry] = k;
  endtask

  task automatic do_search(input logic [127:0] k, input string tag);
    logic [15:0] ev;
    int ei;
    ev = model_vec(k);
    ei = 0;
    for (int j = 15; j >= 0; j--) if (ev[j]) ei = j;
    @(negedge clk);
    srch_valid = 1'b1; srch_key = k;
    @(posedge clk);
    @(negedge clk);
    srch_valid = 1'b0;
    chk(res_valid == 1'b0, "R2", "valid after one edge", 128'(res_valid), 128'd0);
    @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b1, "R2", "valid after two edges", 128'(res_valid), 128'd1);
    chk(res_vec == ev, tag, "hit vector", 128'(res_vec), 128'(ev));
    chk(res_hit == (ev != 0), tag, "hit flag", 128'(res_hit), 128'(ev != 0));
    chk(res_index == 4'(ei), tag, "index", 128'(res_index), 128'(ei));
    @(negedge clk);
    chk(res_valid == 1'b0, "R2", "single-cycle pulse", 128'(res_valid), 128'd0);
  endtask

  task automatic t_reset;
    int cnt;
    for (int j = 0; j < 16; j++) begin mval[j] = 1'b0; mkey[j] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1", "busy in reset", 128'(busy), 128'd1);
    chk(res_valid == 1'b0, "R1", "valid in reset", 128'(res_valid), 128'd0);
    rst_n = 1'b1;
    wait_idle(cnt);
    chk(cnt == 256, "R1", "init sweep cycles", 128'(cnt), 128'd256);
    do_search('0, "R1");
    do_search(mk(1), "R1");
  endtask

  task automatic t_write_hit;
    do_update(1'b1, 5, mk(1), "R3");
    do_search(mk(1), "R3");
  endtask

  task automatic t_byte_miss;
    do_search(mk(1) ^ 128'h01, "R4");
    do_search(mk(1) ^ {8'h80, 120'h0}, "R4");
  endtask

  task automatic t_multi;
    do_update(1'b1, 12, mk(2), "R5");
    do_update(1'b1, 9, mk(2), "R5");
    do_update(1'b1, 2, mk(2), "R5");
    do_search(mk(2), "R5");
  endtask

  task automatic t_edges;
    do_update(1'b1, 15, mk(3), "R5");
    do_update(1'b1, 0, mk(3), "R5");
    do_search(mk(3), "R5");
  endtask

  task automatic t_busy_ignore;
    int cnt;
    int stray;
    stray = 0;
    @(negedge clk);
    upd_valid = 1'b1; upd_op = 1'b1; upd_entry = 4'd7; upd_key = mk(4);
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    for (int c = 0; c < 30; c++) begin
      if (res_valid) stray++;
      srch_valid = 1'b1; srch_key = mk(1);
      if (c == 10) begin
        upd_valid = 1'b1; upd_op = 1'b1; upd_entry = 4'd1; upd_key = mk(5);
      end else begin
        upd_valid = 1'b0;
      end
      @(negedge clk);
    end
    srch_valid = 1'b0; upd_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      if (res_valid) stray++;
      @(negedge clk);
    end
    chk(stray == 0, "R7", "result pulses while busy", 128'(stray), 128'd0);
    wait_idle(cnt);
    chk(res_valid == 1'b0, "R7", "valid after sweep", 128'(res_valid), 128'd0);
    mval[7] = 1'b1; mkey[7] = mk(4);
    do_search(mk(5), "R10");
    do_search(mk(4), "R10");
  endtask

  task automatic t_delete;
    do_update(1'b0, 2, '0, "R8");
    do_search(mk(2), "R8");
  endtask

  task automatic t_rewrite;
    do_update(1'b1, 5, mk(6), "R9");
    do_search(mk(1), "R9");
    do_search(mk(6), "R9");
  endtask

  initial begin
    t_reset();
    t_write_hit();
    t_byte_miss();
    t_multi();
    t_edges();
    t_busy_ignore();
    t_delete();
    t_rewrite();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule